// File: doc/BRIEF.md
# Shared-Memory Central Cell Buffer

This block is the central cell store of a small cell switch. Every inlet writes its arriving cells into one common memory of `DEPTH` slots. Each outlet reads only the cells addressed to it. A cell may land in any free slot, so the memory as a whole is neither written nor read in first-in-first-out order. Each outlet still sees its own cells in the order they arrived.

Address management has two parts. A stack of free slot addresses supplies the write locations. For each outlet, head and tail registers and a shared next-slot array form a linked chain through the occupied slots. In one clock cycle the block accepts a cell from any subset of inlets and lets any subset of outlets remove their head cell. When the store runs out of free slots it drops the cell and counts it in a drop counter. A `buf_full` flag reports that no slot is free.

Top module: `shared_cell_store`

## Requirements
- R1: After reset, `out_avail` is all zero, `buf_full` is 0 and `drop_count` is 0.
- R2: A cell presented on inlet i uses `in_data[16i +: 16]` and `in_dest[2i +: 2]`, which names the outlet. It raises `out_avail[d]` one clock after the write, and `out_data[16d +: 16]` shows it. Outlet d reads from `out_data[16d +: 16]`.
- R3: Each outlet delivers its cells in arrival order, even when cells for other outlets arrive in between.
- R4: When several inlets write to the same outlet in one cycle, that outlet delivers them in ascending inlet index order.
- R5: While `out_avail[o]` is 1 and `out_take[o]` is 0, outlet o keeps the same head cell. `out_take[o]` with `out_avail[o]` at 0 has no effect.
- R6: The store holds 16 cells. `buf_full` is 1 exactly when all 16 slots are occupied.
- R7: A write that finds no free slot is dropped, and `drop_count` rises by one for each dropped cell. Stored cells are unaffected. Within one cycle, free slots go to the lower-index inlets first.
- R8: A slot freed by a take can be written in the next cycle but not in the same cycle. A write made while the store is full is dropped even if a take happens in that cycle.
- R9: A cell cannot be taken in the cycle it is written. A take and a write to the same outlet in one cycle both take effect: after a take of the only cell, the new cell becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Per-inlet cell write strobe |
| in_dest | input | N_IN*DW | Per-inlet destination outlet, inlet i at bits [i*DW +: DW] |
| in_data | input | N_IN*W | Per-inlet cell payload, inlet i at bits [i*W +: W] |
| out_take | input | N_OUT | Per-outlet request to remove the head cell |
| out_avail | output | N_OUT | Outlet has at least one stored cell |
| out_data | output | N_OUT*W | Head cell payload per outlet, outlet o at bits [o*W +: W] |
| buf_full | output | 1 | No free slot remains |
| drop_count | output | CW | Running count of dropped cells |

## Verification
A broken chain link shows up as a wrong or repeated payload at an outlet head. It appears on the take that follows the cell before the corrupted link, and it can stay hidden until the queue drains that far. A free stack that leaks or duplicates slots shows up as `buf_full` at the wrong occupancy, or as one cell overwriting another. The bench therefore fills the store completely, overflows it, frees single slots and drains every outlet to empty while checking each payload. A checker that compares the sum of the outlet queue lengths against the free count catches such a leak in the cycle it happens.

// File: rtl/shared_cell_store.sv
module shared_cell_store #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int DEPTH = 16,
  parameter int W     = 16,
  parameter int CW    = 16,
  localparam int DW   = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    in_valid,
  input  logic [N_IN*DW-1:0] in_dest,
  input  logic [N_IN*W-1:0]  in_data,
  input  logic [N_OUT-1:0]   out_take,
  output logic [N_OUT-1:0]   out_avail,
  output logic [N_OUT*W-1:0] out_data,
  output logic               buf_full,
  output logic [CW-1:0]      drop_count
);

  logic [W-1:0]   mem_q [DEPTH];
  logic [AW-1:0]  stk_q [DEPTH];
  logic [AW-1:0]  nxt_q [DEPTH];
  logic [AW-1:0]  hd_q  [N_OUT];
  logic [AW-1:0]  tl_q  [N_OUT];
  logic [SPW-1:0] cnt_q [N_OUT];
  logic [SPW-1:0] sp_q;
  logic [CW-1:0]  drop_q;

  logic [AW-1:0]  stk_n [DEPTH];
  logic [AW-1:0]  nxt_n [DEPTH];
  logic [AW-1:0]  hd_n  [N_OUT];
  logic [AW-1:0]  tl_n  [N_OUT];
  logic [SPW-1:0] cnt_n [N_OUT];
  logic [SPW-1:0] sp_n;
  logic [CW-1:0]  drop_n;

  logic [N_IN-1:0] acc;
  logic [AW-1:0]   wad [N_IN];
  logic [SPW-1:0]  spv, spm1;
  logic [DW-1:0]   d;
  logic [AW-1:0]   a;
  int              nd;

  assign buf_full   = (sp_q == '0);
  assign drop_count = drop_q;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign out_avail[o]        = (cnt_q[o] != '0);
    assign out_data[o*W +: W]  = mem_q[hd_q[o]];
  end

  always_comb begin
    stk_n = stk_q;
    nxt_n = nxt_q;
    hd_n  = hd_q;
    tl_n  = tl_q;
    cnt_n = cnt_q;
    spv   = sp_q;
    spm1  = '0;
    nd    = 0;
    acc   = '0;
    d     = '0;
    a     = '0;
    for (int i = 0; i < N_IN; i++) begin
      wad[i] = '0;
      if (in_valid[i]) begin
        d = in_dest[i*DW +: DW];
        if (spv != '0 && int'(d) < N_OUT) begin
          spm1   = spv - SPW'(1);
          a      = stk_q[spm1[AW-1:0]];
          spv    = spm1;
          acc[i] = 1'b1;
          wad[i] = a;
          if (cnt_n[d] == '0) hd_n[d] = a;
          else                nxt_n[tl_n[d]] = a;
          tl_n[d]  = a;
          cnt_n[d] = cnt_n[d] + SPW'(1);
        end else begin
          nd = nd + 1;
        end
      end
    end
    for (int o = 0; o < N_OUT; o++) begin
      if (out_take[o] && cnt_q[o] != '0) begin
        stk_n[spv[AW-1:0]] = hd_q[o];
        spv      = spv + SPW'(1);
        hd_n[o]  = nxt_n[hd_q[o]];
        cnt_n[o] = cnt_n[o] - SPW'(1);
      end
    end
    sp_n   = spv;
    drop_n = drop_q + CW'(nd);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_IN; i++)
      if (acc[i]) mem_q[wad[i]] <= in_data[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        stk_q[k] <= AW'(k);
        nxt_q[k] <= '0;
      end
      for (int o = 0; o < N_OUT; o++) begin
        hd_q[o]  <= '0;
        tl_q[o]  <= '0;
        cnt_q[o] <= '0;
      end
      sp_q   <= SPW'(DEPTH);
      drop_q <= '0;
    end else begin
      stk_q  <= stk_n;
      nxt_q  <= nxt_n;
      hd_q   <= hd_n;
      tl_q   <= tl_n;
      cnt_q  <= cnt_n;
      sp_q   <= sp_n;
      drop_q <= drop_n;
    end
  end

endmodule

module shared_cell_store_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IN-1:0]  in_valid,
  input logic [N_OUT-1:0] out_take,
  input logic [N_OUT-1:0] out_avail,
  input logic             buf_full,
  input logic [CW-1:0]    drop_count,
  input logic [SPW-1:0]   sp_q,
  input logic [SPW-1:0]   cnt_q [N_OUT]
);

  int used;
  always_comb begin
    used = 0;
    for (int o = 0; o < N_OUT; o++) used = used + int'(cnt_q[o]);
  end

  // R6
  slot_conservation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used + int'(sp_q) == DEPTH);

  // R5
  head_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(out_avail & ~out_take) & ~out_avail) == '0));

  // R7
  no_spurious_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_valid) <= int'(sp_q)) |=> $stable(drop_count));

  // R8
  full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && (in_valid != '0) && ((out_take & out_avail) == '0)) |=> buf_full);

  // R7
  idle_drop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |=> $stable(drop_count));

endmodule

bind shared_cell_store shared_cell_store_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .DEPTH(DEPTH), .CW(CW)
) i_chk (.*);

// File: tb/test_shared_cell_store.sv
module test_shared_cell_store;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_valid = '0;
  logic [7:0]  in_dest = '0;
  logic [63:0] in_data = '0;
  logic [3:0]  out_take = '0;
  logic [3:0]  out_avail;
  logic [63:0] out_data;
  logic        buf_full;
  logic [15:0] drop_count;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  shared_cell_store i_shared_cell_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_take(out_take), .out_avail(out_avail),
    .out_data(out_data), .buf_full(buf_full), .drop_count(drop_count)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [3:0] v, logic [7:0] dst, logic [63:0] dat, logic [3:0] tk);
    in_valid = v; in_dest = dst; in_data = dat; out_take = tk;
    @(posedge clk); #1;
    in_valid = '0; in_dest = '0; in_data = '0; out_take = '0;
  endtask

  task automatic pop_expect(int o, logic [15:0] exp, string tag);
    chk({tag, " avail"}, 32'(out_avail[o]), 32'd1);
    chk({tag, " data"}, 32'(out_data[o*16 +: 16]), 32'(exp));
    cyc(4'b0, 8'b0, 64'b0, 4'(1 << o));
  endtask

  task automatic t_reset();
    chk("R1 out_avail", 32'(out_avail), 32'h0);
    chk("R1 buf_full", 32'(buf_full), 32'h0);
    chk("R1 drop_count", 32'(drop_count), 32'h0);
  endtask

  task automatic t_basic();
    in_valid = 4'b0001; in_dest = 8'h02; in_data = 64'h1111;
    #1 chk("R9 not visible same cycle", 32'(out_avail), 32'h0);
    @(posedge clk); #1;
    in_valid = '0; in_dest = '0; in_data = '0;
    chk("R2 avail after write", 32'(out_avail), 32'h4);
    chk("R2 head data", 32'(out_data[47:32]), 32'h1111);
    cyc(4'b0, 8'b0, 64'b0, 4'b0100);
    chk("R5 take empties", 32'(out_avail), 32'h0);
  endtask

  task automatic t_order();
    cyc(4'b0001, 8'h01, 64'h0000_0000_0000_2001, 4'b0);
    cyc(4'b0010, 8'h0C, 64'h0000_0000_3001_0000, 4'b0);
    cyc(4'b0100, 8'h10, 64'h0000_2002_0000_0000, 4'b0);
    cyc(4'b1001, 8'hC1, 64'h3002_0000_0000_2003, 4'b0);
    chk("R3 avail", 32'(out_avail), 32'hA);
    cyc(4'b0, 8'b0, 64'b0, 4'b0001);
    chk("R5 take on empty ignored", 32'(out_avail), 32'hA);
    chk("R5 take on empty no drop", 32'(drop_count), 32'h0);
    pop_expect(1, 16'h2001, "R3 o1 #1");
    pop_expect(3, 16'h3001, "R3 o3 #1");
    pop_expect(1, 16'h2002, "R3 o1 #2");
    pop_expect(1, 16'h2003, "R3 o1 #3");
    pop_expect(3, 16'h3002, "R3 o3 #2");
    chk("R3 drained", 32'(out_avail), 32'h0);
  endtask

  task automatic t_same_cycle();
    cyc(4'b1011, 8'h00, 64'h4003_0000_4001_4000, 4'b0);
    pop_expect(0, 16'h4000, "R4 inlet0 first");
    pop_expect(0, 16'h4001, "R4 inlet1 second");
    pop_expect(0, 16'h4003, "R4 inlet3 third");
    chk("R4 drained", 32'(out_avail), 32'h0);
  endtask

  task automatic t_hold();
    cyc(4'b0100, 8'h30, 64'h0000_5555_0000_0000, 4'b0);
    for (int k = 0; k < 3; k++) begin
      cyc(4'b0, 8'b0, 64'b0, 4'b0);
      chk("R5 head held", 32'(out_data[63:48]), 32'h5555);
    end
    pop_expect(3, 16'h5555, "R5 final take");
  endtask

  task automatic t_rw_same();
    cyc(4'b0001, 8'h02, 64'h6001, 4'b0);
    cyc(4'b0010, 8'h08, 64'h6002_0000, 4'b0100);
    chk("R9 new head avail", 32'(out_avail), 32'h4);
    chk("R9 new head data", 32'(out_data[47:32]), 32'h6002);
    pop_expect(2, 16'h6002, "R9 drain");
  endtask

  task automatic t_full();
    for (int c = 0; c < 4; c++) begin
      logic [63:0] dat;
      for (int i = 0; i < 4; i++) dat[i*16 +: 16] = 16'hA000 | 16'(c << 4) | 16'(i);
      cyc(4'b1111, 8'b1110_0100, dat, 4'b0);
      chk("R6 full flag", 32'(buf_full), 32'(c == 3));
    end
    cyc(4'b1111, 8'h00, 64'hBAD3_BAD2_BAD1_BAD0, 4'b0);
    chk("R7 four drops", 32'(drop_count), 32'd4);
    chk("R7 still full", 32'(buf_full), 32'h1);
    chk("R7 stored head intact", 32'(out_data[15:0]), 32'hA000);
    cyc(4'b0001, 8'h01, 64'hC001, 4'b0001);
    chk("R8 same-cycle write dropped", 32'(drop_count), 32'd5);
    chk("R8 slot freed", 32'(buf_full), 32'h0);
    cyc(4'b0111, 8'h3F, 64'h0000_C102_C101_C100, 4'b0);
    chk("R7 partial drop", 32'(drop_count), 32'd7);
    chk("R8 reused slot full", 32'(buf_full), 32'h1);
    for (int c = 0; c < 4; c++)
      pop_expect(3, 16'hA003 | 16'(c << 4), "R7 outlet3 order");
    pop_expect(3, 16'hC100, "R7 lowest inlet wins");
    chk("R7 outlet3 drained", 32'(out_avail[3]), 32'h0);
    for (int c = 1; c < 4; c++) pop_expect(0, 16'hA000 | 16'(c << 4), "R6 outlet0");
    for (int c = 0; c < 4; c++) pop_expect(1, 16'hA001 | 16'(c << 4), "R8 outlet1");
    for (int c = 0; c < 4; c++) pop_expect(2, 16'hA002 | 16'(c << 4), "R6 outlet2");
    chk("R6 all empty", 32'(out_avail), 32'h0);
    chk("R6 not full", 32'(buf_full), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_order();
    t_same_cycle();
    t_hold();
    t_rw_same();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule